// File: doc/BRIEF.md
# Horizontal FIR Prefilter

This block smooths a horizontal pixel stream before it is resampled. It takes one luma and one chroma sample per accepted cycle, along with a valid strobe and start-of-line and end-of-line markers. Each channel runs a symmetric low-pass kernel, and each channel has its own 2-bit mode select. Every kernel is scaled so that a flat input passes through at its own level. Results are rounded to nearest and clamped to the sample range.

At the two ends of a line, window positions that fall outside the line take the value of the nearest edge sample. After the last sample of a line, the block shifts its window three more times on its own to finish the tail. The pipeline depth is the same in every mode, so changing a mode never moves pixels relative to the markers.

Top module: `hfir_prefilter`

## Requirements
- R1: While rst_ni is low, valid_o, sol_o and eol_o are 0, and y_o and c_o are 0.
- R2: Mode code 00 is bypass: the output sample equals the input sample.
- R3: Mode code 01 applies weights 1,2,1 centred on the sample. The result is (sum+2)/4, rounded down after adding that offset.
- R4: Mode code 10 applies weights 1,2,2,2,1. The result is (sum+8/2)/8.
- R5: On luma, mode code 11 applies weights 1,1,1.75,4.5,1.75,1,1. It uses quarter units 4,4,7,18,7,4,4, and the result is (sum+24)/48. All-255 input gives 255.
- R6: On chroma, mode code 11 applies weights 3,8,10,8,3, and the result is (sum+16)/32.
- R7: mode_y_i affects only y_o and mode_c_i affects only c_o. Different codes on the two channels may be used in the same line.
- R8: Taps that fall before the first sample or after the last sample of a line use that edge sample. This includes lines of 1, 2 and 3 samples.
- R9: Each accepted sample gives exactly one output, in order. sol_o is set on the first output of a line and eol_o on the last. sol_o and eol_o are only ever set together with valid_o. After eol, valid_i must stay low for 3 cycles while the block drains the line by itself.
- R10: When samples arrive on consecutive cycles, each output appears 4 clock edges after the edge that accepted its input. This holds in every mode and also for the tail samples.
- R11: While valid_i is low and no line is draining, sol_i, eol_i, y_i and c_i have no effect. No output is produced and y_o and c_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| sol_i | input | 1 | First sample of a line |
| eol_i | input | 1 | Last sample of a line |
| mode_y_i | input | 2 | Luma mode: 00 bypass, 01 three-tap, 10 five-tap, 11 strongest |
| mode_c_i | input | 2 | Chroma mode, same codes |
| y_i | input | DW | Luma sample |
| c_i | input | DW | Chroma sample |
| valid_o | output | 1 | Output sample strobe |
| sol_o | output | 1 | First output of a line |
| eol_o | output | 1 | Last output of a line |
| y_o | output | DW | Filtered luma |
| c_o | output | DW | Filtered chroma |

## Verification
The hardest case to reach is a window that is filled with replicated edge samples at both ends at once. This happens on lines shorter than the kernel: the left fill from the first sample and the self-driven tail shifts after the last sample overlap in the window. The bench sends lines of one, two and three samples in the strongest and five-tap modes, using step patterns so that any wrongly replicated neighbour shows up in the rounded result. It also sends lines with idle gaps between samples, so that the output count and order are checked when the window advances unevenly.

// File: rtl/hfir_pkg.sv
package hfir_pkg;
  typedef enum logic [1:0] {
    FM_BYPASS = 2'b00,
    FM_NARROW = 2'b01,
    FM_MID    = 2'b10,
    FM_WIDE   = 2'b11
  } fmode_e;

  localparam int unsigned NTAP = 7;
  localparam int unsigned MID  = NTAP / 2;
endpackage

// File: rtl/hfir_line_ctrl.sv
module hfir_line_ctrl
  import hfir_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sol_i,
  input  logic eol_i,
  output logic shift_o,
  output logic fill_o,
  output logic emit_o,
  output logic sol_o,
  output logic eol_o
);
  localparam int unsigned CW = $clog2(MID + 1);

  logic [CW-1:0]   flush_q;
  logic            shifted_q;
  logic [NTAP-1:0] v_q, s_q, e_q;
  logic [NTAP-2:0] keep;

  assign fill_o  = valid_i & sol_i;
  assign shift_o = valid_i | (flush_q != '0);
  assign keep    = {(NTAP-1){~fill_o}};

  // tail drain: MID extra shifts replicate the last sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= '0;
    end else if (valid_i && eol_i) begin
      flush_q <= CW'(MID);
    end else if (flush_q != '0) begin
      flush_q <= flush_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shifted_q <= 1'b0;
      v_q       <= '0;
      s_q       <= '0;
      e_q       <= '0;
    end else begin
      shifted_q <= shift_o;
      if (shift_o) begin
        v_q <= {v_q[NTAP-2:0] & keep, valid_i};
        s_q <= {s_q[NTAP-2:0] & keep, valid_i & sol_i};
        e_q <= {e_q[NTAP-2:0] & keep, valid_i & eol_i};
      end
    end
  end

  assign emit_o = shifted_q & v_q[MID];
  assign sol_o  = s_q[MID];
  assign eol_o  = e_q[MID];
endmodule

// File: rtl/hfir_tap_line.sv
module hfir_tap_line
  import hfir_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic                     fill_i,
  input  logic                     take_i,
  input  logic [DW-1:0]            din_i,
  output logic [NTAP-1:0][DW-1:0]  win_o
);
  logic [DW-1:0] tap_q [NTAP];

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    if (t == 0) begin : g_head
      // during drain the head holds, replicating the last sample
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tap_q[0] <= '0;
        end else if (shift_i && take_i) begin
          tap_q[0] <= din_i;
        end
      end
    end else begin : g_body
      // line start loads every tap with the first sample
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          tap_q[t] <= '0;
        end else if (shift_i) begin
          tap_q[t] <= fill_i ? din_i : tap_q[t-1];
        end
      end
    end
    assign win_o[t] = tap_q[t];
  end
endmodule

// File: rtl/hfir_kernel.sv
module hfir_kernel
  import hfir_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter bit          LUMA = 1'b1
) (
  input  logic [NTAP-1:0][DW-1:0] win_i,
  input  fmode_e                  mode_i,
  output logic [DW-1:0]           px_o
);
  localparam int unsigned AW = DW + 6;
  localparam logic [AW-1:0] MAXV = AW'((1 << DW) - 1);

  logic [AW-1:0] p [NTAP];
  logic [AW-1:0] narrow_s, mid_s, wide_s, sel;

  for (genvar i = 0; i < NTAP; i++) begin : g_ext
    assign p[i] = AW'(win_i[i]);
  end

  assign narrow_s = (p[2] + (p[3] << 1) + p[4] + AW'(2)) >> 2;
  assign mid_s    = (p[1] + ((p[2] + p[3] + p[4]) << 1) + p[5] + AW'(4)) >> 3;

  if (LUMA) begin : g_luma
    // quarter-unit weights 4 4 7 18 7 4 4, divide by 48 via reciprocal
    localparam int unsigned SH = DW + 12;
    localparam int unsigned PW = AW + SH;
    localparam longint unsigned RECIP = ((64'd1 << SH) + 64'd47) / 64'd48;
    logic [AW-1:0] acc;
    logic [PW-1:0] prod;
    assign acc  = ((p[0] + p[1] + p[5] + p[6]) << 2) + (p[2] + p[4]) * AW'(7)
                + p[3] * AW'(18) + AW'(24);
    assign prod = PW'(acc) * PW'(RECIP);
    assign wide_s = AW'(prod >> SH);
  end else begin : g_chroma
    logic [AW-1:0] acc;
    assign acc = (p[1] + p[5]) * AW'(3) + (p[2] + p[4]) * AW'(8)
               + p[3] * AW'(10) + AW'(16);
    assign wide_s = acc >> 5;
  end

  always_comb begin
    unique case (mode_i)
      FM_NARROW: sel = narrow_s;
      FM_MID:    sel = mid_s;
      FM_WIDE:   sel = wide_s;
      default:   sel = p[MID];
    endcase
    px_o = (sel > MAXV) ? MAXV[DW-1:0] : sel[DW-1:0];
  end
endmodule

// File: rtl/hfir_prefilter.sv
module hfir_prefilter
  import hfir_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sol_i,
  input  logic          eol_i,
  input  logic [1:0]    mode_y_i,
  input  logic [1:0]    mode_c_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] c_i,
  output logic          valid_o,
  output logic          sol_o,
  output logic          eol_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o
);
  logic shift, fill, emit, ctl_sol, ctl_eol;
  logic [NTAP-1:0][DW-1:0] y_win, c_win;
  logic [DW-1:0] y_px, c_px;

  hfir_line_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sol_i   (sol_i),
    .eol_i   (eol_i),
    .shift_o (shift),
    .fill_o  (fill),
    .emit_o  (emit),
    .sol_o   (ctl_sol),
    .eol_o   (ctl_eol)
  );

  hfir_tap_line #(.DW(DW)) u_y_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .fill_i  (fill),
    .take_i  (valid_i),
    .din_i   (y_i),
    .win_o   (y_win)
  );

  hfir_tap_line #(.DW(DW)) u_c_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .fill_i  (fill),
    .take_i  (valid_i),
    .din_i   (c_i),
    .win_o   (c_win)
  );

  hfir_kernel #(.DW(DW), .LUMA(1'b1)) u_y_kernel (
    .win_i  (y_win),
    .mode_i (fmode_e'(mode_y_i)),
    .px_o   (y_px)
  );

  hfir_kernel #(.DW(DW), .LUMA(1'b0)) u_c_kernel (
    .win_i  (c_win),
    .mode_i (fmode_e'(mode_c_i)),
    .px_o   (c_px)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sol_o   <= 1'b0;
      eol_o   <= 1'b0;
      y_o     <= '0;
      c_o     <= '0;
    end else begin
      valid_o <= emit;
      sol_o   <= emit & ctl_sol;
      eol_o   <= emit & ctl_eol;
      if (emit) begin
        y_o <= y_px;
        c_o <= c_px;
      end
    end
  end
endmodule

// File: rtl/hfir_prefilter_chk.sv
module hfir_prefilter_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          sol_i,
  input logic          eol_i,
  input logic [1:0]    mode_y_i,
  input logic [1:0]    mode_c_i,
  input logic [DW-1:0] y_i,
  input logic [DW-1:0] c_i,
  input logic          valid_o,
  input logic          sol_o,
  input logic          eol_o,
  input logic [DW-1:0] y_o,
  input logic [DW-1:0] c_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_rst_R1: assert (!valid_o && !sol_o && !eol_o && y_o == '0 && c_o == '0);
    end
  end

  assert_bypass_y_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i, 5) && $past(valid_i, 4) && $past(valid_i, 3) && $past(valid_i, 2)
     && $past(mode_y_i, 1) == 2'b00) |-> (valid_o && y_o == $past(y_i, 5)));

  assert_bypass_c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i, 5) && $past(valid_i, 4) && $past(valid_i, 3) && $past(valid_i, 2)
     && $past(mode_c_i, 1) == 2'b00) |-> (valid_o && c_o == $past(c_i, 5)));

  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i && sol_i, 5) && $past(valid_i, 4) && $past(valid_i, 3) && $past(valid_i, 2))
    |-> (valid_o && sol_o));

  assert_tail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && eol_i, 5) |-> (valid_o && eol_o));

  assert_marker_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_o || eol_o) |-> valid_o);
endmodule

bind hfir_prefilter hfir_prefilter_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .sol_i    (sol_i),
  .eol_i    (eol_i),
  .mode_y_i (mode_y_i),
  .mode_c_i (mode_c_i),
  .y_i      (y_i),
  .c_i      (c_i),
  .valid_o  (valid_o),
  .sol_o    (sol_o),
  .eol_o    (eol_o),
  .y_o      (y_o),
  .c_o      (c_o)
);

// File: tb/hfir_prefilter_tb.sv
module hfir_prefilter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int MAXL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, sol_i = 1'b0, eol_i = 1'b0;
  logic [1:0] mode_y = 2'b00, mode_c = 2'b00;
  logic [DW-1:0] y_i = '0, c_i = '0;
  logic valid_o, sol_o, eol_o;
  logic [DW-1:0] y_o, c_o;

  int tests = 0, fails = 0, cyc = 0, n_out = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;
  int iy[MAXL], ic[MAXL], acyc[MAXL];
  int oy[MAXL], oc[MAXL], ocyc[MAXL];
  bit os[MAXL], oe[MAXL];

  hfir_prefilter #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sol_i(sol_i), .eol_i(eol_i),
    .mode_y_i(mode_y), .mode_c_i(mode_c), .y_i(y_i), .c_i(c_i),
    .valid_o(valid_o), .sol_o(sol_o), .eol_o(eol_o), .y_o(y_o), .c_o(c_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (n_out < MAXL) begin
        oy[n_out] = int'(y_o); oc[n_out] = int'(c_o);
        os[n_out] = sol_o; oe[n_out] = eol_o; ocyc[n_out] = cyc;
      end
      n_out++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int getp(bit ch, int len, int j);
    int jj = (j < 0) ? 0 : ((j > len - 1) ? len - 1 : j);
    return ch ? ic[jj] : iy[jj];
  endfunction

  function automatic int ref_px(bit ch, int len, int k, int md);
    int a;
    case (md)
      1: return (getp(ch,len,k-1) + 2*getp(ch,len,k) + getp(ch,len,k+1) + 2) / 4;
      2: return (getp(ch,len,k-2) + 2*(getp(ch,len,k-1) + getp(ch,len,k) + getp(ch,len,k+1))
                 + getp(ch,len,k+2) + 4) / 8;
      3: begin
        if (!ch) begin
          a = 4*getp(ch,len,k-3) + 4*getp(ch,len,k-2) + 7*getp(ch,len,k-1) + 18*getp(ch,len,k)
            + 7*getp(ch,len,k+1) + 4*getp(ch,len,k+2) + 4*getp(ch,len,k+3);
          return (a + 24) / 48;
        end
        a = 3*getp(ch,len,k-2) + 8*getp(ch,len,k-1) + 10*getp(ch,len,k)
          + 8*getp(ch,len,k+1) + 3*getp(ch,len,k+2);
        return (a + 16) / 32;
      end
      default: return getp(ch, len, k);
    endcase
  endfunction

  function automatic string mode_req(int md, bit ch);
    case (md)
      1: return "R3";
      2: return "R4";
      3: return ch ? "R6" : "R5";
      default: return "R2";
    endcase
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  task automatic fill(int len, int kind);
    for (int k = 0; k < len; k++) begin
      case (kind)
        1: begin iy[k] = 255; ic[k] = 255; end
        2: begin iy[k] = (k < len/2) ? 0 : 255; ic[k] = (k % 2 == 1) ? 255 : 0; end
        default: begin iy[k] = next_rand(); ic[k] = next_rand(); end
      endcase
    end
  endtask

  task automatic send_line(int len, int my, int mc, bit gaps, string label);
    n_out = 0;
    @(negedge clk);
    mode_y = 2'(my); mode_c = 2'(mc);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      valid_i = 1'b1; sol_i = (k == 0); eol_i = (k == len - 1);
      y_i = DW'(iy[k]); c_i = DW'(ic[k]);
      acyc[k] = cyc + 1;
      if (gaps && (k % 3 == 1) && k != len - 1) begin
        @(negedge clk);
        valid_i = 1'b0; sol_i = 1'b0; eol_i = 1'b0; y_i = 8'hA5;
      end
    end
    @(negedge clk);
    valid_i = 1'b0; sol_i = 1'b0; eol_i = 1'b0;
    repeat (8) @(negedge clk);
    check(n_out == len, "R9", {label, " output count"}, n_out, len);
    for (int k = 0; k < len && k < n_out && k < MAXL; k++) begin
      check(oy[k] == ref_px(1'b0, len, k, my), {mode_req(my, 1'b0), " ", label},
            $sformatf("y[%0d]", k), oy[k], ref_px(1'b0, len, k, my));
      check(oc[k] == ref_px(1'b1, len, k, mc), {mode_req(mc, 1'b1), " ", label},
            $sformatf("c[%0d]", k), oc[k], ref_px(1'b1, len, k, mc));
      check(os[k] == (k == 0), "R9", $sformatf("%s sol[%0d]", label, k), int'(os[k]), int'(k == 0));
      check(oe[k] == (k == len - 1), "R9", $sformatf("%s eol[%0d]", label, k),
            int'(oe[k]), int'(k == len - 1));
      if (!gaps)
        check(ocyc[k] - acyc[k] == 4, "R10", $sformatf("%s latency[%0d]", label, k),
              ocyc[k] - acyc[k], 4);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && sol_o == 1'b0 && eol_o == 1'b0, "R1", "flags in reset",
          int'({valid_o, sol_o, eol_o}), 0);
    check(y_o == '0 && c_o == '0, "R1", "data in reset", int'({y_o, c_o}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_bypass();
    fill(12, 0); send_line(12, 0, 0, 1'b0, "bypass R2");
  endtask

  task automatic t_narrow();
    fill(16, 0); send_line(16, 1, 1, 1'b0, "three-tap R3");
    fill(10, 2); send_line(10, 1, 1, 1'b0, "three-tap step R3");
  endtask

  task automatic t_mid();
    fill(16, 0); send_line(16, 2, 2, 1'b0, "five-tap R4");
    fill(10, 2); send_line(10, 2, 2, 1'b0, "five-tap step R4");
  endtask

  task automatic t_wide();
    fill(20, 0); send_line(20, 3, 3, 1'b0, "strongest R5 R6");
    fill(12, 2); send_line(12, 3, 3, 1'b0, "strongest step R5 R6");
  endtask

  task automatic t_saturate();
    for (int md = 0; md < 4; md++) begin
      fill(9, 1); send_line(9, md, md, 1'b0, "full scale R5");
    end
  endtask

  task automatic t_mixed();
    fill(14, 0); send_line(14, 3, 0, 1'b0, "independent R7");
    fill(14, 0); send_line(14, 0, 3, 1'b0, "independent R7");
    fill(14, 0); send_line(14, 1, 2, 1'b0, "independent R7");
  endtask

  task automatic t_edges();
    for (int len = 1; len <= 3; len++) begin
      fill(len, 0); send_line(len, 3, 3, 1'b0, "short line R8");
      fill(len, 2); send_line(len, 2, 3, 1'b0, "short step R8");
    end
    iy[0] = 255; iy[1] = 0; ic[0] = 0; ic[1] = 200;
    send_line(2, 3, 3, 1'b0, "two-sample R8");
  endtask

  task automatic t_gaps();
    fill(17, 0); send_line(17, 3, 1, 1'b1, "gapped R9");
    fill(5, 0);  send_line(5, 2, 3, 1'b1, "gapped short R9");
  endtask

  task automatic t_idle();
    logic [DW-1:0] y_prev, c_prev;
    int vo_seen = 0;
    n_out = 0;
    @(negedge clk);
    y_prev = y_o; c_prev = c_o;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      valid_i = 1'b0; sol_i = 1'b1; eol_i = 1'b1;
      y_i = DW'(next_rand()); c_i = DW'(next_rand());
      if (valid_o) vo_seen++;
    end
    @(negedge clk);
    sol_i = 1'b0; eol_i = 1'b0;
    repeat (6) @(negedge clk);
    check(n_out == 0 && vo_seen == 0, "R11", "outputs while idle", n_out + vo_seen, 0);
    check(y_o == y_prev, "R11", "y_o held while idle", int'(y_o), int'(y_prev));
    check(c_o == c_prev, "R11", "c_o held while idle", int'(c_o), int'(c_prev));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_bypass();
    t_narrow();
    t_mid();
    t_wide();
    t_saturate();
    t_mixed();
    t_edges();
    t_gaps();
    t_idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule